// File: doc/BRIEF.md
# Two-Level Sticky Interrupt Aggregator

This block folds seventeen serial-interrupt request lines and eight bus error events into a single interrupt output. It does so through two cascaded stages, and each stage holds its own latched status. The first stage latches every request into a status word. It ANDs that word with a mask, and it forwards a single summary bit only while a global enable is set. The summary appears as one bit of the second stage's read-only raw-input word. The second stage latches the masked raw input into its own sticky status word. The interrupt output is high whenever that word is non-zero.

Software reaches both stages through a 32-bit register port. Bit 31 of each word is the most significant bit. Both status words are cleared by writing ones. A polarity word and two firmware-window words (a segment select and a read access size) are held in storage only and have no effect on the logic. Reads have no side effects and return data in the same cycle as the address.

Top module: `irq_cascade_agg`

## Requirements
- R1: After reset every register reads zero except the read access size at offset 0x28, which reads 0x02000000, and `irq_out` is low.
- R2: Each cycle in which `sirq_in[n]` is high sets first-stage status bit (31 - n) at offset 0x38. The bit stays set after the input drops.
- R3: Each cycle in which `err_in[k]` is high sets first-stage status bit k (k = 0..7). The bit stays set after the input drops.
- R4: A write to offset 0x38 clears the status bits written as one. When a bit is set by its input in the same cycle as it is cleared, the set wins.
- R5: Bit 11 of the raw-input word at offset 0x5c equals (control bit 31) AND (status 0x38 AND mask 0x34 is non-zero). The other bits of this word read zero, and writes to offset 0x5c are ignored.
- R6: On every clock edge the second-stage status at offset 0x50 ORs in (raw input AND mask at offset 0x54). Its bits stay set until software writes ones to them. If the masked raw input is still active in that cycle, the bit sets again.
- R7: `irq_out` is high exactly when the second-stage status word is non-zero. It follows a change of that word in the same cycle.
- R8: The polarity word at offset 0x58 reads back what was written. Its value does not change the interrupt path.
- R9: Reads of offsets with no register return 0xFFFFFFFF, and writes to them are ignored. The error address word at offset 0x40 reads zero and ignores writes.
- R10: Writes to the control (0x30), first-stage mask (0x34), second-stage mask (0x54), segment select (0x24) and access size (0x28) words replace their contents, and each word reads back the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sirq_in | input | 17 | Serial-interrupt request levels, one per line |
| err_in | input | 8 | Bus error event levels |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Aggregated interrupt |

## Verification
The register map is driven through a vector table covering reset values, read-back words, ignored writes and unmapped offsets. These cases separate correct decoding from stored, discarded and all-ones behaviour. Requests are then raised on the first, last and a middle serial line and on one error line, to test that each bit position is mapped correctly. The enable and the two masks are opened one at a time, which shows that each gate alone blocks the path. The clear cases include a clear that collides with an active input at each stage, a clear of the first stage that leaves the second stage latched, and a polarity write, which tests that polarity is inert.

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg #(
  parameter int NUM_SIRQ = 17,
  parameter int NUM_ERR  = 8,
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int LINK_BIT = 11,
  parameter logic [31:0] ACC_RST = 32'h0200_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SIRQ-1:0] sirq_in,
  input  logic [NUM_ERR-1:0]  err_in,
  input  logic                reg_we,
  input  logic [AW-1:0]       reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  output logic                irq_out
);
  localparam logic [AW-1:0] OFF_SEG  = AW'('h24);
  localparam logic [AW-1:0] OFF_ACC  = AW'('h28);
  localparam logic [AW-1:0] OFF_CTL  = AW'('h30);
  localparam logic [AW-1:0] OFF_MSK1 = AW'('h34);
  localparam logic [AW-1:0] OFF_ST1  = AW'('h38);
  localparam logic [AW-1:0] OFF_EADR = AW'('h40);
  localparam logic [AW-1:0] OFF_ST2  = AW'('h50);
  localparam logic [AW-1:0] OFF_MSK2 = AW'('h54);
  localparam logic [AW-1:0] OFF_POL  = AW'('h58);
  localparam logic [AW-1:0] OFF_RAW2 = AW'('h5c);

  logic [DW-1:0] seg, acc, ctl, msk1, st1, st2, msk2, pol;
  logic [DW-1:0] set_vec, raw2;
  logic          s1;

  wire wr_seg  = reg_we && reg_addr == OFF_SEG;
  wire wr_acc  = reg_we && reg_addr == OFF_ACC;
  wire wr_ctl  = reg_we && reg_addr == OFF_CTL;
  wire wr_msk1 = reg_we && reg_addr == OFF_MSK1;
  wire wr_st1  = reg_we && reg_addr == OFF_ST1;
  wire wr_st2  = reg_we && reg_addr == OFF_ST2;
  wire wr_msk2 = reg_we && reg_addr == OFF_MSK2;
  wire wr_pol  = reg_we && reg_addr == OFF_POL;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NUM_SIRQ; i++) set_vec[DW-1-i] = sirq_in[i];
    set_vec[NUM_ERR-1:0] = err_in;
  end

  assign s1      = ctl[DW-1] & (|(st1 & msk1));
  assign raw2    = DW'(s1) << LINK_BIT;
  assign irq_out = |st2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg  <= '0;
      acc  <= ACC_RST;
      ctl  <= '0;
      msk1 <= '0;
      st1  <= '0;
      st2  <= '0;
      msk2 <= '0;
      pol  <= '0;
    end else begin
      if (wr_seg)  seg  <= reg_wdata;
      if (wr_acc)  acc  <= reg_wdata;
      if (wr_ctl)  ctl  <= reg_wdata;
      if (wr_msk1) msk1 <= reg_wdata;
      if (wr_msk2) msk2 <= reg_wdata;
      if (wr_pol)  pol  <= reg_wdata;
      st1 <= (st1 & ~(wr_st1 ? reg_wdata : '0)) | set_vec;
      st2 <= (st2 & ~(wr_st2 ? reg_wdata : '0)) | (raw2 & msk2);
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_SEG:  reg_rdata = seg;
      OFF_ACC:  reg_rdata = acc;
      OFF_CTL:  reg_rdata = ctl;
      OFF_MSK1: reg_rdata = msk1;
      OFF_ST1:  reg_rdata = st1;
      OFF_EADR: reg_rdata = '0;
      OFF_ST2:  reg_rdata = st2;
      OFF_MSK2: reg_rdata = msk2;
      OFF_POL:  reg_rdata = pol;
      OFF_RAW2: reg_rdata = raw2;
      default:  reg_rdata = '1;
    endcase
  end

  // R2
  sirq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st1 & $past(set_vec)) == $past(set_vec)));

  // R4
  st1_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st1 |=> ((st1 & $past(reg_wdata) & ~$past(set_vec)) == '0));

  // R6
  st2_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_st2 |=> ((st2 & $past(st2)) == $past(st2)));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> ($past(raw2 & msk2) != '0));

  // R10
  ctl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (ctl == $past(reg_wdata)));
endmodule

// File: tb/irq_cascade_agg_tb.sv
`timescale 1ns/1ps
module irq_cascade_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] sirq_in = '0;
  logic [7:0]  err_in = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_cascade_agg dut_i (
    .clk(clk), .rst_n(rst_n), .sirq_in(sirq_in), .err_in(err_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // {req[3:0], write, addr[7:0], data[31:0]}
  localparam int NV = 22;
  localparam logic [44:0] VEC [NV] = '{
    {4'd1, 1'b0, 8'h28, 32'h0200_0000},  // R1
    {4'd1, 1'b0, 8'h38, 32'h0},          // R1
    {4'd1, 1'b0, 8'h30, 32'h0},          // R1
    {4'd1, 1'b0, 8'h50, 32'h0},          // R1
    {4'd1, 1'b0, 8'h5c, 32'h0},          // R1
    {4'd9, 1'b0, 8'h44, 32'hFFFF_FFFF},  // R9
    {4'd9, 1'b0, 8'h40, 32'h0},          // R9
    {4'd10,1'b1, 8'h24, 32'h1234_5678},
    {4'd10,1'b0, 8'h24, 32'h1234_5678},  // R10
    {4'd10,1'b1, 8'h28, 32'h0700_0000},
    {4'd10,1'b0, 8'h28, 32'h0700_0000},  // R10
    {4'd8, 1'b1, 8'h58, 32'hA5A5_A5A5},
    {4'd8, 1'b0, 8'h58, 32'hA5A5_A5A5},  // R8
    {4'd5, 1'b1, 8'h5c, 32'hFFFF_FFFF},
    {4'd5, 1'b0, 8'h5c, 32'h0},          // R5
    {4'd9, 1'b1, 8'h40, 32'h0000_FFFF},
    {4'd9, 1'b0, 8'h40, 32'h0},          // R9
    {4'd9, 1'b1, 8'h44, 32'h1},
    {4'd9, 1'b0, 8'h44, 32'hFFFF_FFFF},  // R9
    {4'd10,1'b1, 8'h54, 32'hDEAD_0000},
    {4'd10,1'b0, 8'h54, 32'hDEAD_0000},  // R10
    {4'd10,1'b0, 8'h34, 32'h0}           // R10
  };

  task automatic chk(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input int req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a; #1;
    chk(req, $sformatf("read %h", a), reg_rdata, exp);
  endtask

  task automatic pulse_sirq(input int n);
    @(negedge clk); sirq_in[n] = 1'b1;
    @(negedge clk); sirq_in[n] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(1, "irq_out after reset", 32'(irq_out), 32'h0); // R1
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:0]);
      else rd(int'(VEC[i][44:41]), VEC[i][39:32], VEC[i][31:0]);
    end
    wr(8'h54, 32'h0);
    // R2: first, last and middle lines
    pulse_sirq(0);
    rd(2, 8'h38, 32'h8000_0000);
    pulse_sirq(16);
    pulse_sirq(5);
    rd(2, 8'h38, 32'h8400_8000);
    // R3
    @(negedge clk); err_in[3] = 1'b1;
    @(negedge clk); err_in[3] = 1'b0;
    rd(3, 8'h38, 32'h8400_8008);
    rd(5, 8'h5c, 32'h0);
    // R5: mask open but enable off
    wr(8'h34, 32'h8000_0000);
    rd(5, 8'h5c, 32'h0);
    wr(8'h30, 32'h8000_0000);
    rd(5, 8'h5c, 32'h0000_0800);
    @(posedge clk); #1;
    // R6: second-stage mask closed
    rd(6, 8'h50, 32'h0);
    chk(7, "irq_out mask2 closed", 32'(irq_out), 32'h0);
    wr(8'h54, 32'h0000_0800);
    @(posedge clk); #1;
    rd(6, 8'h50, 32'h0000_0800);
    chk(7, "irq_out raised", 32'(irq_out), 32'h1);
    // R4 clears stage one; R6 stage two stays latched
    wr(8'h38, 32'h8000_0000);
    rd(4, 8'h38, 32'h0400_8008);
    rd(5, 8'h5c, 32'h0);
    @(posedge clk); #1;
    rd(6, 8'h50, 32'h0000_0800);
    chk(7, "irq_out sticky", 32'(irq_out), 32'h1);
    wr(8'h50, 32'h0000_0800);
    rd(6, 8'h50, 32'h0);
    chk(7, "irq_out cleared", 32'(irq_out), 32'h0);
    // R8: polarity has no effect
    wr(8'h58, 32'hFFFF_FFFF);
    @(posedge clk); #1;
    chk(8, "irq_out after polarity", 32'(irq_out), 32'h0);
    // R4: set wins over clear
    @(negedge clk); sirq_in[1] = 1'b1;
    wr(8'h38, 32'h4000_0000);
    rd(4, 8'h38, 32'h4400_8008);
    // R6: clear of stage two while raw input still active
    wr(8'h34, 32'h4000_0000);
    @(posedge clk); #1;
    chk(7, "irq_out via line 1", 32'(irq_out), 32'h1);
    wr(8'h50, 32'h0000_0800);
    rd(6, 8'h50, 32'h0000_0800);
    @(negedge clk); sirq_in[1] = 1'b0;
    wr(8'h38, 32'h4000_0000);
    rd(4, 8'h38, 32'h0400_8008);
    // R5: enable off gates the summary
    wr(8'h30, 32'h0);
    rd(10, 8'h30, 32'h0);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(4, 8'h38, 32'h0);
    wr(8'h50, 32'hFFFF_FFFF);
    rd(5, 8'h5c, 32'h0);
    chk(7, "irq_out final", 32'(irq_out), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule